// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block is the transmit half of an asynchronous serial port. A host pushes bytes in through a one-cycle write strobe. The bytes go into a 16-entry first-in first-out queue, or into a single holding slot when queueing is switched off. A shift register turns each byte into a character on one output line: a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. With 5-bit words the two-stop setting gives one and a half stop bits.

A separate divider supplies a one-cycle sampling tick. The tick runs at 16, 8 or 4 times the bit rate, and the ratio is selected by a 2-bit field. The block reports two conditions: nothing is waiting to be shifted (holding empty), and the whole channel has drained (transmitter empty). It also raises an interrupt request that tells the host to refill the queue. Change the configuration inputs only while the transmitter-empty output is high.

Top module: `uart_tx_fifo`

## Requirements
- R1: One bit lasts a number of ticks set by `os_sel`: 00 gives 16, 01 gives 8, 10 gives 4, and 11 gives 16. The serial output changes only in the cycle after a tick.
- R2: A character is sent as one low start bit, then the data bits with bit 0 first, then the parity bit if enabled, then the stop bits at high level.
- R3: `word_len` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7, and 11 gives 8. Unused upper bits of the written byte are not sent.
- R4: With `par_en` high, the parity bit is set by `par_mode`: 00 gives even parity (bit equals the XOR of the data bits), 01 gives odd parity (its inverse), 10 gives a constant 1, and 11 gives a constant 0. With `par_en` low, no parity bit is sent.
- R5: `stop2` low sends one stop bit. `stop2` high sends two, except with 5-bit words, where the second stop bit lasts half a bit time.
- R6: The line idles high. If a byte is waiting, it loads into the shifter on a tick while the shifter is idle, or on the tick that ends the last stop bit, so characters follow each other with no gap.
- R7: With `fifo_en` high, up to 16 bytes are queued and sent in write order. A write to a full queue is dropped.
- R8: With `fifo_en` low, a single holding slot is used. A write while that slot is occupied is dropped.
- R9: `hold_empty` is high exactly when no byte is waiting. In either mode it rises in the cycle after the last waiting byte moves into the shifter.
- R10: `tx_empty` is high only when no byte is waiting and the shifter has finished its last stop bit.
- R11: With `fifo_en` and `irq_en` high, `irq` is high while the fill level is below the trigger level set by `trig_sel` (00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14). It drops once writes lift the level to the trigger or above.
- R12: With `fifo_en` low and `irq_en` high, `irq` follows `hold_empty`. With `irq_en` low, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Sampling tick, one cycle wide |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to send |
| fifo_en | input | 1 | 1 selects the 16-entry queue, 0 selects the single slot |
| os_sel | input | 2 | Ticks per bit |
| word_len | input | 2 | Data bits per character |
| par_en | input | 1 | Parity bit enable |
| par_mode | input | 2 | Parity kind |
| stop2 | input | 1 | Second stop bit (half length with 5-bit words) |
| trig_sel | input | 2 | Interrupt trigger level in queue mode |
| irq_en | input | 1 | Interrupt enable |
| txd | output | 1 | Serial output |
| hold_empty | output | 1 | No byte waiting |
| tx_empty | output | 1 | Queue and shifter both empty |
| irq | output | 1 | Transmit-empty interrupt request |

## Verification
The assertions check, on every cycle, the relations that hold between the outputs at any moment. The line stays high when the channel is empty, and it changes only after a tick. The fill level never goes above the capacity of the selected mode. Holding-empty stays set unless a write arrives. The interrupt is masked when disabled, and in single-slot mode it tracks holding-empty.

Only the bench's scenarios can show whether each character has the right bit order, width, parity value and stop length, whether dropped writes leave the sent stream untouched, and whether back-to-back characters start on the tick that ends the previous frame. The bench shows this by comparing the line against a queue-based model in every cycle.

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       fifo_en,
  input  logic [1:0] os_sel,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic [1:0] par_mode,
  input  logic       stop2,
  input  logic [1:0] trig_sel,
  input  logic       irq_en,
  output logic       txd,
  output logic       hold_empty,
  output logic       tx_empty,
  output logic       irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cap, trig;
  logic          busy, half_q;
  logic [3:0]    tcnt, bidx, nb_q, wl, nb;
  logic [11:0]   sh, frame;
  logic [4:0]    blen, clen;
  logic [7:0]    din, dmask;
  logic          pbit, last, bit_end, load, wr_ok;

  assign cap        = fifo_en ? CW'(DEPTH) : CW'(1);
  assign wr_ok      = wr_en && (cnt < cap);
  assign hold_empty = (cnt == '0);
  assign tx_empty   = hold_empty && !busy;

  always_comb
    case (trig_sel)
      2'b00:   trig = CW'(1);
      2'b01:   trig = CW'(4);
      2'b10:   trig = CW'(8);
      default: trig = CW'(14);
    endcase

  assign irq = irq_en && (fifo_en ? (cnt < trig) : hold_empty);

  always_comb
    case (os_sel)
      2'b01:   blen = 5'd8;
      2'b10:   blen = 5'd4;
      default: blen = 5'd16;
    endcase

  assign last    = (bidx == nb_q - 4'd1);
  assign clen    = (last && half_q) ? {1'b0, blen[4:1]} : blen;
  assign bit_end = busy && tick && ({1'b0, tcnt} == clen - 5'd1);
  assign load    = tick && !hold_empty && (!busy || (bit_end && last));

  assign wl  = 4'd5 + {2'b00, word_len};
  assign nb  = 4'd2 + wl + {3'b000, par_en} + {3'b000, stop2};
  assign din = mem[rp];

  always_comb begin
    for (int i = 0; i < 8; i++) dmask[i] = (i < int'(wl)) ? din[i] : 1'b0;
    case (par_mode)
      2'b00:   pbit = ^dmask;
      2'b01:   pbit = ~^dmask;
      2'b10:   pbit = 1'b1;
      default: pbit = 1'b0;
    endcase
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(wl)) frame[i+1] = din[i];
    if (par_en) frame[wl + 4'd1] = pbit;
  end

  always_ff @(posedge clk)
    if (wr_ok) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (load)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(wr_ok) - CW'(load);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy   <= 1'b0;
      txd    <= 1'b1;
      sh     <= '1;
      tcnt   <= '0;
      bidx   <= '0;
      nb_q   <= 4'd10;
      half_q <= 1'b0;
    end else if (load) begin
      busy   <= 1'b1;
      txd    <= 1'b0;
      sh     <= frame;
      tcnt   <= '0;
      bidx   <= '0;
      nb_q   <= nb;
      half_q <= stop2 && (word_len == 2'b00);
    end else if (bit_end) begin
      tcnt <= '0;
      if (last) begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end else begin
        sh   <= {1'b1, sh[11:1]};
        txd  <= sh[1];
        bidx <= bidx + 4'd1;
      end
    end else if (busy && tick) begin
      tcnt <= tcnt + 4'd1;
    end
endmodule

module uart_tx_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr_en,
  input logic          fifo_en,
  input logic          irq_en,
  input logic          txd,
  input logic          hold_empty,
  input logic          tx_empty,
  input logic          irq,
  input logic [CW-1:0] cnt
);
  AST_IDLE_HIGH:    assert property (@(posedge clk) disable iff (!rst_n) tx_empty |-> txd); // R6
  AST_TXD_ON_TICK:  assert property (@(posedge clk) disable iff (!rst_n) !$stable(txd) |-> $past(tick)); // R1
  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R7
  AST_SINGLE_SLOT:  assert property (@(posedge clk) disable iff (!rst_n) !fifo_en |-> cnt <= CW'(1)); // R8
  AST_HOLD_KEEPS:   assert property (@(posedge clk) disable iff (!rst_n) hold_empty && !wr_en |=> hold_empty); // R9
  AST_DRAIN_ORDER:  assert property (@(posedge clk) disable iff (!rst_n) tx_empty |-> hold_empty); // R10
  AST_IRQ_MASKED:   assert property (@(posedge clk) disable iff (!rst_n) !irq_en |-> !irq); // R11
  AST_SLOT_IRQ:     assert property (@(posedge clk) disable iff (!rst_n) (!fifo_en && irq_en) |-> (irq == hold_empty)); // R12
endmodule

bind uart_tx_fifo uart_tx_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .fifo_en(fifo_en),
  .irq_en(irq_en), .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty),
  .irq(irq), .cnt(cnt)
);

// File: tb/sim_uart_tx_fifo.sv
`timescale 1ns/1ps
module sim_uart_tx_fifo;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic fifo_en = 1'b0, par_en = 1'b0, stop2 = 1'b0, irq_en = 1'b0;
  logic [1:0] os_sel = '0, word_len = 2'b11, par_mode = '0, trig_sel = '0;
  logic txd, hold_empty, tx_empty, irq;

  uart_tx_fifo u0 (.*);

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  string tag = "R2";
  int tick_div = 1, tcount = 0;

  int  q[$];
  bit  fb[$];
  int  fl[$];
  int  m_cnt = 0;
  bit  m_busy = 0, m_txd = 1;

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", r, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (tcount + 1 >= tick_div) begin tick <= 1'b1; tcount = 0; end
    else begin tick <= 1'b0; tcount++; end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); fb.delete(); fl.delete();
      m_cnt = 0; m_busy = 0; m_txd = 1;
    end else begin
      int pre;
      int n, wl, d, ev, cap;
      pre = q.size();
      n = (os_sel == 2'b01) ? 8 : (os_sel == 2'b10) ? 4 : 16;
      if (tick && m_busy) begin
        m_cnt++;
        if (m_cnt == fl[0]) begin
          void'(fb.pop_front()); void'(fl.pop_front());
          m_cnt = 0;
          if (fb.size() == 0) m_busy = 0;
        end
      end
      if (tick && !m_busy && pre > 0) begin
        d = q.pop_front();
        wl = 5 + word_len;
        ev = 0;
        fb.push_back(0); fl.push_back(n);
        for (int i = 0; i < wl; i++) begin
          fb.push_back(d[i]); fl.push_back(n); ev ^= d[i];
        end
        if (par_en) begin
          fb.push_back(par_mode == 0 ? ev[0] : par_mode == 1 ? !ev[0] : par_mode == 2);
          fl.push_back(n);
        end
        fb.push_back(1); fl.push_back(n);
        if (stop2) begin fb.push_back(1); fl.push_back(wl == 5 ? n / 2 : n); end
        m_busy = 1; m_cnt = 0;
      end
      cap = fifo_en ? 16 : 1;
      if (wr_en && pre < cap) q.push_back(wr_data);
      m_txd = m_busy ? fb[0] : 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int trig;
      bit mi;
      trig = trig_sel == 0 ? 1 : trig_sel == 1 ? 4 : trig_sel == 2 ? 8 : 14;
      mi = irq_en && (fifo_en ? (q.size() < trig) : (q.size() == 0));
      chk(txd == m_txd, tag, "txd", txd, m_txd);
      chk(hold_empty == (q.size() == 0), "R9", "hold_empty", hold_empty, q.size() == 0);
      chk(tx_empty == (q.size() == 0 && !m_busy), "R10", "tx_empty", tx_empty, q.size() == 0 && !m_busy);
      chk(irq == mi, fifo_en ? "R11" : "R12", "irq", irq, mi);
    end
  end

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en <= 1'b1; wr_data <= b;
    @(negedge clk); wr_en <= 1'b0;
  endtask

  task automatic burst(input int k, input int seed);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); wr_en <= 1'b1; wr_data <= 8'(seed * 37 + i * 11);
    end
    @(negedge clk); wr_en <= 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (!tx_empty || m_busy || q.size() != 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg(input bit f, input logic [1:0] os, input logic [1:0] w,
                     input bit pe, input logic [1:0] pm, input bit s2, input int td);
    @(negedge clk);
    fifo_en <= f; os_sel <= os; word_len <= w; par_en <= pe; par_mode <= pm; stop2 <= s2;
    tick_div = td;
  endtask

  initial begin
    bit wd = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R6", "reset txd", txd, 1);
        chk(hold_empty == 1'b1, "R9", "reset hold_empty", hold_empty, 1);
        chk(tx_empty == 1'b1, "R10", "reset tx_empty", tx_empty, 1);
        chk(irq == 1'b0, "R12", "reset irq", irq, 0);
        rst_n <= 1'b1;
        repeat (2) @(negedge clk);

        tag = "R2"; cfg(0, 2'b00, 2'b11, 0, 0, 0, 2);
        wr(8'hA5); drain(); wr(8'h3C); drain();

        tag = "R8"; irq_en <= 1'b1; cfg(0, 2'b00, 2'b11, 1, 0, 0, 2);
        wr(8'h81); wr(8'h42); wr(8'h99);
        @(negedge clk);
        chk(hold_empty == 1'b0, "R8", "slot occupied", hold_empty, 0);
        drain();

        tag = "R7"; trig_sel <= 2'b10; cfg(1, 2'b01, 2'b10, 1, 0, 1, 3);
        burst(18, 1); drain();

        tag = "R11"; trig_sel <= 2'b11; cfg(1, 2'b10, 2'b11, 0, 0, 0, 1);
        burst(13, 2);
        chk(irq == 1'b1, "R11", "below trigger", irq, 1);
        burst(3, 3); drain();

        tag = "R1"; irq_en <= 1'b0; cfg(1, 2'b10, 2'b11, 0, 0, 0, 1);
        burst(3, 4); drain();
        cfg(1, 2'b11, 2'b11, 0, 0, 0, 1); burst(2, 5); drain();

        tag = "R5"; cfg(1, 2'b10, 2'b00, 1, 2'b01, 1, 2);
        burst(4, 6); drain();
        cfg(1, 2'b01, 2'b01, 0, 0, 1, 1); burst(2, 7); drain();

        tag = "R3";
        for (int w = 0; w < 4; w++) begin
          cfg(1, 2'b10, 2'(w), 0, 0, 0, 1); wr(8'hFF ^ 8'(w)); drain();
        end

        tag = "R4";
        for (int p = 0; p < 4; p++)
          for (int w = 0; w < 4; w++) begin
            cfg(1, 2'b10, 2'(w), 1, 2'(p), 0, 1); burst(2, p * 4 + w); drain();
          end

        tag = "R6"; trig_sel <= 2'b00; irq_en <= 1'b1; cfg(1, 2'b10, 2'b11, 0, 0, 1, 1);
        burst(6, 9); drain();
      end
      begin
        repeat (150000) @(posedge clk);
        wd = 1;
      end
    join_any
    disable fork;
    if (wd) begin
      tests++; fails++;
      $display("FAIL R6 watchdog actual=1 expected=0");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule